// File: doc/BRIEF.md
# EEPROM Page Write Buffer

This block sits behind the serial command decoder of a small serial EEPROM. During a page-write command it collects the incoming data bytes into a one-page staging buffer. Each byte goes to the column that the running column pointer names, and the page number taken from the start address stays fixed. When chip select rises at the end of the command, the block decides whether the page may be committed. If so, it enters a modelled self-timed programming period. During that period it copies every loaded byte into the memory array, one byte per clock, and it holds a busy flag for a parameterised number of cycles.

The command decoder supplies a start strobe with the address, one strobe per received byte, and a pulse when chip select rises. With that pulse comes a flag that says whether the rise fell on a whole-byte boundary. The status logic supplies the write-enable bit, and the protection logic supplies a flag telling whether the addressed page lies in a protected range. The block drives array write strobes with address and data, a busy flag, and a one-cycle done pulse. The status logic uses the done pulse to clear its write-enable bit.

Top module: `eeprom_page_wbuf`

## Requirements
- R1: A `cmd_start` pulse while `busy` is 0 captures `start_addr`. The upper ADDR_W-COL_W bits select the page, and that page is held for the whole command. Every array write of the resulting commit carries this page in `arr_addr[ADDR_W-1:COL_W]`.
- R2: Each `byte_valid` strobe during a command stores `byte_data` at the current column and then advances the column by one. The column wraps from PAGE_BYTES-1 to 0 inside the same page, so when more than PAGE_BYTES bytes arrive, the value loaded last at each column is the one written.
- R3: A `cs_rise` pulse ends the command. A commit starts only if `cs_aligned` is 1 in that cycle and at least one byte was loaded; a byte strobe in the same cycle as `cs_rise` counts as loaded. In every other case nothing is written and `busy` stays 0.
- R4: A commit also requires `wen`=1 and `page_prot`=0 in the `cs_rise` cycle. Otherwise the command ends with no write.
- R5: After a commit, `busy` is 1 from the cycle after `cs_rise` for exactly WAIT_CYCLES cycles. `done` is a single-cycle pulse in the first cycle in which `busy` is 0 again.
- R6: During `busy`, `arr_we` pulses once for each loaded column and never for a column that was not loaded, in ascending column order and at most one write per cycle. The write for column k appears in busy cycle k+1, where busy cycle 0 is the first.
- R7: While `busy` is 1, `cmd_start`, `byte_valid` and `cs_rise` are ignored. Byte strobes and `cs_rise` pulses that arrive outside a command are also ignored, so they cause no write and no busy period.
- R8: After reset `busy`, `done` and `arr_we` are 0 and no command is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Page-write command address received |
| start_addr | input | ADDR_W | Byte address given by the command |
| byte_valid | input | 1 | One data byte received |
| byte_data | input | DATA_W | Received data byte |
| cs_rise | input | 1 | Chip select has risen |
| cs_aligned | input | 1 | The rise fell on a byte boundary |
| wen | input | 1 | Write-enable status bit |
| page_prot | input | 1 | Addressed page is protected |
| arr_we | output | 1 | Array byte write strobe |
| arr_addr | output | ADDR_W | Array byte address |
| arr_wdata | output | DATA_W | Array write data |
| busy | output | 1 | Programming period running |
| done | output | 1 | Programming finished, one-cycle pulse |

## Verification
Two events can meet in one cycle: the strobe of the last data byte and the chip-select rise that closes the command. The bench drives both in the same cycle, once with that byte as the only one loaded and once with it as the last of several. The commit must start, and that column must be written with the new value. A behavioural reference model, fed the same inputs, predicts `busy`, `done`, `arr_we`, `arr_addr` and `arr_wdata` on every clock and judges the outcome.

// File: rtl/eeprom_wbuf_pkg.sv
package eeprom_wbuf_pkg;
  typedef enum logic {
    LD_IDLE   = 1'b0,
    LD_ACTIVE = 1'b1
  } load_phase_t;
endpackage

// File: rtl/eeprom_wbuf_mem.sv
module eeprom_wbuf_mem #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  parameter int AW     = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  // simple dual-port RAM, registered read
  always_ff @(posedge clk) begin
    if (we) store_q[waddr] <= wdata;
    rdata_q <= store_q[raddr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/eeprom_wbuf_ctrl.sv
module eeprom_wbuf_ctrl
  import eeprom_wbuf_pkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int PAGE_BYTES = 64,
  parameter int COL_W      = 6,
  parameter int PAGE_W     = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmd_start,
  input  logic [ADDR_W-1:0]     start_addr,
  input  logic                  byte_valid,
  input  logic                  cs_rise,
  input  logic                  cs_aligned,
  input  logic                  wen,
  input  logic                  page_prot,
  input  logic                  busy,
  output logic                  loading,
  output logic                  go,
  output logic                  buf_we,
  output logic [COL_W-1:0]      buf_waddr,
  output logic [PAGE_W-1:0]     page_q,
  output logic [PAGE_BYTES-1:0] mask_q
);
  load_phase_t      phase_q;
  logic [COL_W-1:0] col_q;
  logic             accept_cmd, take_byte, any_byte;

  assign accept_cmd = cmd_start && !busy;
  assign loading    = (phase_q == LD_ACTIVE);
  assign take_byte  = loading && byte_valid && !accept_cmd;
  assign any_byte   = (mask_q != '0) || take_byte;
  assign go         = loading && !accept_cmd && cs_rise && cs_aligned &&
                      wen && !page_prot && any_byte;
  assign buf_we     = take_byte;
  assign buf_waddr  = col_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= LD_IDLE;
      page_q  <= '0;
      col_q   <= '0;
      mask_q  <= '0;
    end else if (accept_cmd) begin
      phase_q <= LD_ACTIVE;
      page_q  <= start_addr[ADDR_W-1:COL_W];
      col_q   <= start_addr[COL_W-1:0];
      mask_q  <= '0;
    end else if (loading) begin
      if (byte_valid) begin
        mask_q[col_q] <= 1'b1;
        col_q         <= col_q + 1'b1;   // wraps inside the page
      end
      if (cs_rise) phase_q <= LD_IDLE;
    end
  end

  assert_page_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (loading && !cmd_start) |=> $stable(page_q));
endmodule

// File: rtl/eeprom_wbuf_prog.sv
module eeprom_wbuf_prog #(
  parameter int ADDR_W      = 14,
  parameter int PAGE_BYTES  = 64,
  parameter int COL_W       = 6,
  parameter int PAGE_W      = 8,
  parameter int WAIT_CYCLES = 250000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  go,
  input  logic [PAGE_BYTES-1:0] mask,
  input  logic [PAGE_W-1:0]     page,
  output logic [COL_W-1:0]      rd_addr,
  output logic                  arr_we,
  output logic [ADDR_W-1:0]     arr_addr,
  output logic                  busy,
  output logic                  done
);
  localparam int CNT_W = $clog2(WAIT_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYCLES - 1);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(PAGE_BYTES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [COL_W-1:0] ptr_q;
  logic             scan_q;

  assign rd_addr = ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      arr_we   <= 1'b0;
      arr_addr <= '0;
      cnt_q    <= '0;
      ptr_q    <= '0;
      scan_q   <= 1'b0;
    end else begin
      done   <= 1'b0;
      arr_we <= 1'b0;
      if (busy) begin
        cnt_q <= cnt_q + 1'b1;
        if (scan_q) begin
          arr_we   <= mask[ptr_q];
          arr_addr <= {page, ptr_q};
          ptr_q    <= ptr_q + 1'b1;
          if (ptr_q == COL_LAST) scan_q <= 1'b0;
        end
        if (cnt_q == CNT_LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (go) begin
        busy   <= 1'b1;
        cnt_q  <= '0;
        ptr_q  <= '0;
        scan_q <= 1'b1;
      end
    end
  end

  assert_done_edge_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_we_in_busy_R6: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy);
endmodule

// File: rtl/eeprom_page_wbuf.sv
module eeprom_page_wbuf #(
  parameter int ADDR_W      = 14,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 64,
  parameter int WAIT_CYCLES = 250000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              cs_rise,
  input  logic              cs_aligned,
  input  logic              wen,
  input  logic              page_prot,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata,
  output logic              busy,
  output logic              done
);
  localparam int COL_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - COL_W;

  logic                  loading, go, buf_we;
  logic [COL_W-1:0]      buf_waddr, rd_addr;
  logic [PAGE_W-1:0]     page_q;
  logic [PAGE_BYTES-1:0] mask_q;

  eeprom_wbuf_ctrl #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .COL_W(COL_W), .PAGE_W(PAGE_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .start_addr(start_addr),
    .byte_valid(byte_valid), .cs_rise(cs_rise), .cs_aligned(cs_aligned),
    .wen(wen), .page_prot(page_prot), .busy(busy), .loading(loading),
    .go(go), .buf_we(buf_we), .buf_waddr(buf_waddr), .page_q(page_q),
    .mask_q(mask_q)
  );

  eeprom_wbuf_mem #(
    .DEPTH(PAGE_BYTES), .DATA_W(DATA_W), .AW(COL_W)
  ) u_mem (
    .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(byte_data),
    .raddr(rd_addr), .rdata(arr_wdata)
  );

  eeprom_wbuf_prog #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .COL_W(COL_W), .PAGE_W(PAGE_W),
    .WAIT_CYCLES(WAIT_CYCLES)
  ) u_prog (
    .clk(clk), .rst(rst), .go(go), .mask(mask_q), .page(page_q),
    .rd_addr(rd_addr), .arr_we(arr_we), .arr_addr(arr_addr),
    .busy(busy), .done(done)
  );

  assert_commit_gate_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cs_rise && cs_aligned));
  assert_commit_perm_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wen && !page_prot));
  assert_no_load_busy_R7: assert property (@(posedge clk) disable iff (rst)
    busy |-> !loading);
  assert_write_loaded_R6: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> mask_q[arr_addr[COL_W-1:0]]);
endmodule

// File: tb/eeprom_page_wbuf_tb.sv
module eeprom_page_wbuf_tb;
  localparam int AW = 14;
  localparam int DW = 8;
  localparam int PB = 64;
  localparam int W  = 80;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_start = 1'b0, byte_valid = 1'b0, cs_rise = 1'b0, cs_aligned = 1'b0;
  logic wen = 1'b1, page_prot = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [DW-1:0] byte_data = '0;
  logic arr_we, busy, done;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_wdata;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  eeprom_page_wbuf #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PB), .WAIT_CYCLES(W)) u_dut (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .start_addr(start_addr),
    .byte_valid(byte_valid), .byte_data(byte_data), .cs_rise(cs_rise),
    .cs_aligned(cs_aligned), .wen(wen), .page_prot(page_prot),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .busy(busy), .done(done)
  );

  // behavioural reference model
  bit m_load, m_busy, m_done, m_we;
  int m_page, m_col, m_age, m_addr, m_data;
  int m_buf [PB];
  bit m_mask [PB];

  function automatic bit any_loaded();
    for (int i = 0; i < PB; i++) if (m_mask[i]) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_load = 0; m_busy = 0; m_done = 0; m_we = 0;
      for (int i = 0; i < PB; i++) m_mask[i] = 0;
    end else begin
      m_done = 0; m_we = 0;
      if (m_busy) begin
        m_age++;
        if (m_age - 1 < PB) begin
          if (m_mask[m_age-1]) begin
            m_we = 1; m_addr = m_page * PB + (m_age - 1); m_data = m_buf[m_age-1];
          end
        end
        if (m_age == W) begin m_busy = 0; m_done = 1; end
      end else if (cmd_start) begin
        m_load = 1; m_page = int'(start_addr) / PB; m_col = int'(start_addr) % PB;
        for (int i = 0; i < PB; i++) m_mask[i] = 0;
      end else if (m_load) begin
        if (byte_valid) begin
          m_buf[m_col] = int'(byte_data); m_mask[m_col] = 1; m_col = (m_col + 1) % PB;
        end
        if (cs_rise) begin
          m_load = 0;
          if (cs_aligned && wen && !page_prot && any_loaded()) begin
            m_busy = 1; m_age = 0;
          end
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R5 busy", int'(busy), int'(m_busy));
      chk("R5 done", int'(done), int'(m_done));
      chk("R6 arr_we", int'(arr_we), int'(m_we));
      if (m_we && arr_we) begin
        chk("R1 arr_addr", int'(arr_addr), m_addr);
        chk("R2 arr_wdata", int'(arr_wdata), m_data);
      end
    end
  end

  task automatic do_cmd(int addr);
    cmd_start = 1; start_addr = AW'(addr);
    @(negedge clk); cmd_start = 0;
  endtask

  task automatic do_byte(int d);
    byte_valid = 1; byte_data = DW'(d);
    @(negedge clk); byte_valid = 0;
  endtask

  task automatic do_cs(bit al);
    cs_rise = 1; cs_aligned = al;
    @(negedge clk); cs_rise = 0; cs_aligned = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R8 reset state
    chk("R8 busy after reset", int'(busy), 0);
    chk("R8 arr_we after reset", int'(arr_we), 0);
    chk("R8 done after reset", int'(done), 0);

    // basic short page write (R1, R2, R5, R6)
    do_cmd('h0123);
    for (int i = 0; i < 4; i++) do_byte('h10 + i);
    do_cs(1);
    chk("R5 busy after commit", int'(busy), 1);
    idle(W + 4);

    // R2 wrap: 70 bytes starting at column 60
    do_cmd('h3A * PB + 60);
    for (int i = 0; i < 70; i++) do_byte(i * 3 + 1);
    do_cs(1);
    idle(W + 4);

    // R3 unaligned chip-select rise
    do_cmd('h0200);
    for (int i = 0; i < 3; i++) do_byte('hA0 + i);
    do_cs(0);
    idle(2);
    chk("R3 no commit on unaligned rise", int'(busy), 0);

    // R3 no data bytes
    do_cmd('h0300);
    do_cs(1);
    idle(2);
    chk("R3 no commit without data", int'(busy), 0);

    // R4 write enable clear
    wen = 0;
    do_cmd('h0400); do_byte('h55); do_cs(1);
    idle(2);
    chk("R4 no commit with wen=0", int'(busy), 0);
    wen = 1;

    // R4 protected page
    page_prot = 1;
    do_cmd('h0500); do_byte('h66); do_cs(1);
    page_prot = 0;
    idle(2);
    chk("R4 no commit on protected page", int'(busy), 0);

    // R3 last byte and chip-select rise in the same cycle, single byte
    do_cmd('h0611);
    byte_valid = 1; byte_data = 8'hC3; cs_rise = 1; cs_aligned = 1;
    @(negedge clk);
    byte_valid = 0; cs_rise = 0; cs_aligned = 0;
    chk("R3 same-cycle byte commits", int'(busy), 1);
    idle(W + 4);

    // same coincidence after several bytes
    do_cmd('h0720);
    do_byte('h01); do_byte('h02);
    byte_valid = 1; byte_data = 8'hEE; cs_rise = 1; cs_aligned = 1;
    @(negedge clk);
    byte_valid = 0; cs_rise = 0; cs_aligned = 0;
    idle(5);

    // R7 command attempted while busy
    do_cmd('h0900); do_byte('h77); do_byte('h78);
    idle(W);
    do_cs(1);
    idle(2);
    chk("R7 busy-time command ignored", int'(busy), 0);
    chk("R7 no stray write", int'(arr_we), 0);

    // R7 strobes outside a command
    do_byte('h99); do_cs(1);
    idle(2);
    chk("R7 stray strobes ignored", int'(busy), 0);

    // full page from column 0
    do_cmd('h0A40);
    for (int i = 0; i < PB; i++) do_byte(255 - i);
    do_cs(1);
    idle(W + 4);

    summary();
  end
endmodule